// File: doc/BRIEF.md
# SDI Scrambler and NRZI Channel Encoder

This block is the channel coder for a 10-bit serial digital video link. On each clock where `valid` is high it takes one 10-bit video word and handles its bits in order, least significant bit first. Each bit passes through a self-synchronizing scrambler with generator x^9 + x^4 + 1. The scrambled bit then goes through an x + 1 stage, which is NRZI coding. The ten coded bits of the word come out together as a parallel word, and a serializer downstream sends them out LSB first.

Scrambler history and the NRZI level carry over from one word to the next. The serial stream is therefore the same as if a single bit-serial coder had run over the whole word sequence. Clock cycles with `valid` low do not take part in the stream. The receiver undoes both stages with a matching descrambler, which locks onto the stream within nine bits with no side channel. Some data words meeting some scrambler states give long runs of one output level. This low-frequency content stresses cable equalizers and clock recovery, so the encoder is also the place where that behaviour is measured.

Top module: `sdi_chan_enc`

## Requirements
- R1: While `rst` is high, `dout` reads zero in the following cycle. Reset clears the 9-bit scrambler history and the NRZI level, so the first word after reset is coded from the all-zero state.
- R2: Each scrambled bit is s(i) = d(i) XOR s(i-4) XOR s(i-9). Here s(i-k) is the scrambled bit produced k bits earlier in the serial stream, counting across word boundaries.
- R3: Bit 0 of `din` is the first serial bit and bit 9 the last, and `dout` bit k carries the coded result of `din` bit k. From the reset state, word 001h codes to 10Fh and word 200h codes to 200h.
- R4: Each output bit is n(i) = s(i) XOR n(i-1). For bit 0, n(i-1) is bit 9 of the previously coded word.
- R5: `dout` takes the coded value of a word at the same rising edge that samples that word with `valid` high.
- R6: While `valid` is low, `dout`, the scrambler history and the NRZI level are all held. A word sent after an idle gap codes exactly as it would with no gap.
- R7: A descrambler given only the `dout` stream, starting from any history and level, recovers every word from the second coded word onward.
- R8: With the state at zero, a stream of 000h words codes to 000h on every word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Accept `din` at this edge |
| din | input | 10 | Parallel video word, bit 0 sent first |
| dout | output | 10 | Scrambled, NRZI-coded word, bit 0 first |

## Verification
The bench builds the block with the default widths: 10-bit words, a 9-stage history and taps at 4 and 9. These are the only values that produce the run-length behaviour of a serial video link, so checkfield pairs such as 300h/198h and the 200h-then-004h case can be exercised as they occur on a real link. With the 9-stage history shorter than one word, a descrambler starting from a wrong state resynchronizes within the first word, and the second word already gives a clean round-trip check. The longest run of equal output bits is measured on the coder output and compared with the bench model.

// File: rtl/sdi_enc_pkg.sv
package sdi_enc_pkg;
    localparam int WORD_W_DEF = 10;
    localparam int HIST_W_DEF = 9;
    localparam int TAP_NEAR_DEF = 4;
    localparam int TAP_FAR_DEF = 9;

    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_CODE = 1'b1
    } enc_step_e;
endpackage

// File: rtl/sdi_scr_step.sv
module sdi_scr_step #(
    parameter int WORD_W = 10,
    parameter int HIST_W = 9,
    parameter int TAP_NEAR = 4,
    parameter int TAP_FAR = 9
) (
    input  logic [HIST_W-1:0] hist_in,
    input  logic [WORD_W-1:0] data_in,
    output logic [WORD_W-1:0] scr_out,
    output logic [HIST_W-1:0] hist_out
);
    // chain[i][k-1] holds the scrambled bit from k bits before serial bit i
    logic [HIST_W-1:0] chain [0:WORD_W];

    assign chain[0] = hist_in;

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        assign scr_out[i] = data_in[i] ^ chain[i][TAP_FAR-1] ^ chain[i][TAP_NEAR-1];
        assign chain[i+1] = {chain[i][HIST_W-2:0], scr_out[i]};
    end

    assign hist_out = chain[WORD_W];
endmodule

// File: rtl/sdi_nrzi_step.sv
module sdi_nrzi_step #(
    parameter int WORD_W = 10
) (
    input  logic              level_in,
    input  logic [WORD_W-1:0] scr_in,
    output logic [WORD_W-1:0] line_out
);
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        if (i == 0) begin : g_first
            assign line_out[i] = scr_in[i] ^ level_in;
        end else begin : g_rest
            assign line_out[i] = scr_in[i] ^ line_out[i-1];
        end
    end
endmodule

// File: rtl/sdi_chan_enc.sv
module sdi_chan_enc
    import sdi_enc_pkg::*;
#(
    parameter int WORD_W = WORD_W_DEF,
    parameter int HIST_W = HIST_W_DEF,
    parameter int TAP_NEAR = TAP_NEAR_DEF,
    parameter int TAP_FAR = TAP_FAR_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    localparam int LAST = WORD_W - 1;

    logic [HIST_W-1:0] hist_q, hist_d;
    logic [WORD_W-1:0] scr_w, line_w, dout_q;
    enc_step_e step;

    always_comb begin
        step = valid ? ST_CODE : ST_HOLD;
    end

    sdi_scr_step #(
        .WORD_W(WORD_W), .HIST_W(HIST_W),
        .TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR)
    ) u_scr (
        .hist_in(hist_q), .data_in(din),
        .scr_out(scr_w), .hist_out(hist_d)
    );

    // NRZI level is the last serial bit already sent: bit LAST of dout_q
    sdi_nrzi_step #(.WORD_W(WORD_W)) u_nrzi (
        .level_in(dout_q[LAST]), .scr_in(scr_w), .line_out(line_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            dout_q <= '0;
        end else begin
            unique case (step)
                ST_CODE: begin
                    hist_q <= hist_d;
                    dout_q <= line_w;
                end
                ST_HOLD: begin
                    hist_q <= hist_q;
                    dout_q <= dout_q;
                end
                default: begin
                    hist_q <= hist_q;
                    dout_q <= dout_q;
                end
            endcase
        end
    end

    assign dout = dout_q;
endmodule

// File: rtl/sdi_chan_enc_chk.sv
module sdi_chan_enc_chk #(
    parameter int WORD_W = 10,
    parameter int HIST_W = 9,
    parameter int TAP_NEAR = 4,
    parameter int TAP_FAR = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              valid,
    input logic [WORD_W-1:0] din,
    input logic [WORD_W-1:0] dout
);
    logic              v_q;
    logic [WORD_W-1:0] d_q;
    logic              h_lvl;
    logic [HIST_W-1:0] h_scr;
    logic [HIST_W-1:0] h_tmp;
    logic [WORD_W-1:0] rec;
    logic              lvl_tmp;
    logic              s_bit;

    // Independent descrambler driven only by the coded output
    always_comb begin
        h_tmp = h_scr;
        lvl_tmp = h_lvl;
        rec = '0;
        s_bit = 1'b0;
        for (int i = 0; i < WORD_W; i++) begin
            s_bit = dout[i] ^ lvl_tmp;
            lvl_tmp = dout[i];
            rec[i] = s_bit ^ h_tmp[TAP_FAR-1] ^ h_tmp[TAP_NEAR-1];
            h_tmp = {h_tmp[HIST_W-2:0], s_bit};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= 1'b0;
            d_q <= '0;
            h_lvl <= 1'b0;
            h_scr <= '0;
        end else begin
            v_q <= valid;
            d_q <= din;
            if (v_q) begin
                h_lvl <= lvl_tmp;
                h_scr <= h_tmp;
            end
        end
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> (dout == '0));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(dout));

    // R2 R4 R5
    round_trip_chk: assert property (@(posedge clk) disable iff (rst)
        v_q |-> (rec == d_q));

    // R8
    zero_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && din == '0 && dout == '0 && h_scr == '0 && !v_q) |=> (dout == '0));
endmodule

bind sdi_chan_enc sdi_chan_enc_chk #(
    .WORD_W(WORD_W), .HIST_W(HIST_W), .TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR)
) u_chk (
    .clk(clk), .rst(rst), .valid(valid), .din(din), .dout(dout)
);

// File: tb/sdi_chan_enc_test.sv
`timescale 1ns/1ps
module sdi_chan_enc_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       valid = 1'b0;
    logic [9:0] din = '0;
    logic [9:0] dout;

    int n_run = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model state
    logic [8:0] m_hist = '0;
    logic       m_lvl = 1'b0;
    logic [9:0] m_out = '0;

    // receiver model, started from a wrong state
    logic [8:0] r_hist = 9'h1A5;
    logic       r_lvl = 1'b1;
    int         r_words = 0;

    // run-length tracking
    logic dut_last = 1'b0, mdl_last = 1'b0;
    int   dut_cur = 0, mdl_cur = 0, dut_max = 0, mdl_max = 0;

    sdi_chan_enc uut (.clk(clk), .rst(rst), .valid(valid), .din(din), .dout(dout));

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %03h expected %03h", req, act, exp);
        end
    endtask

    task automatic mdl_code(input logic [9:0] d);
        logic s;
        for (int i = 0; i < 10; i++) begin
            s = d[i] ^ m_hist[8] ^ m_hist[3];
            m_hist = {m_hist[7:0], s};
            m_lvl = s ^ m_lvl;
            m_out[i] = m_lvl;
        end
    endtask

    task automatic rx_word(input logic [9:0] w, output logic [9:0] d);
        logic s;
        for (int i = 0; i < 10; i++) begin
            s = w[i] ^ r_lvl;
            r_lvl = w[i];
            d[i] = s ^ r_hist[8] ^ r_hist[3];
            r_hist = {r_hist[7:0], s};
        end
    endtask

    task automatic track_runs(input logic [9:0] a, input logic [9:0] b);
        for (int i = 0; i < 10; i++) begin
            if (a[i] == dut_last) dut_cur++; else dut_cur = 1;
            dut_last = a[i];
            if (dut_cur > dut_max) dut_max = dut_cur;
            if (b[i] == mdl_last) mdl_cur++; else mdl_cur = 1;
            mdl_last = b[i];
            if (mdl_cur > mdl_max) mdl_max = mdl_cur;
        end
    endtask

    // one cycle: drive at negedge, check the next negedge (R5)
    task automatic step(input logic v, input logic [9:0] w, input string req);
        logic [9:0] rd;
        valid = v;
        din = w;
        @(negedge clk);
        if (v) mdl_code(w);
        check(req, dout, m_out);
        if (v) begin
            track_runs(dout, m_out);
            rx_word(dout, rd);
            r_words++;
            if (r_words >= 2) check("R7 round trip", rd, w);
        end
    endtask

    task automatic do_reset;
        rst = 1'b1;
        valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset output", dout, 10'h000);
        rst = 1'b0;
        m_hist = '0;
        m_lvl = 1'b0;
        m_out = '0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        // R3 bit order, direct values from reset state
        valid = 1'b1; din = 10'h001;
        @(negedge clk);
        check("R3 001h from reset", dout, 10'h10F);
        do_reset();
        valid = 1'b1; din = 10'h200;
        @(negedge clk);
        check("R3 200h from reset", dout, 10'h200);
        do_reset();
        // R8 zero stream from zero state
        for (int k = 0; k < 8; k++) begin
            valid = 1'b1; din = 10'h000;
            @(negedge clk);
            check("R8 zero stream", dout, 10'h000);
        end
        do_reset();
        r_hist = 9'h1A5; r_lvl = 1'b1; r_words = 0;
        // R2 R4 checkfield pair and the 200h/004h case
        for (int k = 0; k < 60; k++) step(1'b1, (k % 2 == 0) ? 10'h300 : 10'h198, "R2 checkfield");
        for (int k = 0; k < 20; k++) step(1'b1, (k % 2 == 0) ? 10'h200 : 10'h004, "R4 200h/004h");
        // R6 idle gap with garbage on din
        for (int k = 0; k < 5; k++) step(1'b0, 10'h3FF, "R6 idle hold");
        step(1'b1, 10'h155, "R6 after gap");
        // random traffic with idle cycles
        for (int k = 0; k < 3000; k++) begin
            logic v;
            v = ($urandom % 5) != 0;
            step(v, 10'($urandom), "R2 R4 random");
        end
        n_run++;
        if (dut_max != mdl_max) begin
            n_bad++;
            $display("FAIL R4 longest run: got %0d expected %0d", dut_max, mdl_max);
        end
        $display("[TB] longest run of equal output bits: %0d", dut_max);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule